// File: doc/BRIEF.md
# Three-Wire Serial Configuration Memory Responder

This block stands in for a small serial configuration memory of 64 words by 16 bits, seen from a host through three wires: a select line, a serial clock and a serial data input, with one serial data output coming back. The host raises select and clocks in a command frame. The frame is a start bit, a two-bit operation code and a six-bit word address. For a read, the block drives one zero bit and then shifts the addressed word out most significant bit first, one bit for each rising edge of the serial clock.

The word store is filled when reset is applied and does not change afterwards. Three fixed identity words go in at the bottom of the store. A 48-bit station address, given as a parameter, fills three consecutive words further up. When the last data bit of a read has been shifted out, the block clears its shift state and waits for the next start bit. The host can therefore run read after read without dropping select. The block does not step on to the following address. Dropping select at any time abandons the frame in progress. The serial inputs pass through synchronisers into the block's own clock domain, and rising edges of the serial clock are found from the synchronised copy.

Top module: `mw_eeprom_responder`

## Requirements
- R1: After reset, word 0 reads 0x8129, word 1 reads 0x10EC and word 2 reads 0x8139. Words 7, 8 and 9 hold the station address. Taking byte k as bits [47-8k:40-8k] of the 48-bit parameter, word 7+j is {byte 2j+1, byte 2j}. Every other word reads 0.
- R2: While select is low, data-out is 0. While select is high and the block is waiting for a start bit or collecting command bits, data-out is 1.
- R3: While waiting for a start bit, a rising serial clock edge with data-in at 0 is ignored and the block keeps waiting.
- R4: A command is taken on rising serial clock edges in this order: a start bit of 1, then a two-bit operation code sent first bit first, where 10 means read, then six address bits sent most significant bit first.
- R5: For a read, data-out is 0 from the rising edge that takes the last address bit until the next rising edge.
- R6: After that dummy bit, each rising edge presents the next bit of the addressed word on data-out, starting with bit 15 and ending with bit 0.
- R7: The rising edge after bit 0 has been presented returns the block to waiting for a start bit, with data-out at 1. Data-in on that edge is ignored. The next command can follow with select held high, and the address does not advance.
- R8: Dropping select at any point abandons the current frame. Once select is raised again, the block waits for a new start bit.
- R9: The operation codes 00, 01 and 11 are accepted without effect. After their address bits the block returns to waiting for a start bit with data-out at 1, and the stored words do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised |
| sel_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |

## Verification
Two situations are the hardest to reach: the edge that closes a read while data-in is already high, and a frame cut off by select partway through. In both, a faulty design still puts out plausible bits. The stimulus holds data-in high on the closing edge and then sends a complete new read; a start bit taken at the wrong moment shifts every later field and gives a wrong word. Seeded random runs add leading idle zeros, drop select after a random number of bits, and mix in non-read operation codes between full reads whose expected words come from a bench function.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int OPC_W = 2;
  localparam logic [OPC_W-1:0] OPC_READ = 2'b10;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_OPC   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DUMMY = 3'd3,
    ST_READ  = 3'd4
  } mw_state_t;

endpackage

// File: rtl/mw_line_sync.sv
module mw_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic rst_n_s,
  output logic sel_s,
  output logic sdi_s,
  output logic sclk_rise
);

  localparam int LINES = 3;

  // reset release synchroniser
  logic [RST_STAGES-1:0] rst_chain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_chain_q[RST_STAGES-1];

  // data line synchronisers, one chain per line
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] synced;
  assign raw_lines = {sclk_i, sdi_i, sel_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) chain_q <= '0;
      else          chain_q <= {chain_q[SYNC_STAGES-2:0], raw_lines[l]};
    end
    assign synced[l] = chain_q[SYNC_STAGES-1];
  end

  logic sclk_prev_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sclk_prev_q <= 1'b0;
    else          sclk_prev_q <= synced[2];
  end

  assign sel_s     = synced[0];
  assign sdi_s     = synced[1];
  assign sclk_rise = synced[2] & ~sclk_prev_q;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int          ADDR_W       = 6,
  parameter int          DATA_W       = 16,
  parameter logic [15:0] ID_WORD0     = 16'h8129,
  parameter logic [15:0] ID_WORD1     = 16'h10EC,
  parameter logic [15:0] ID_WORD2     = 16'h8139,
  parameter int          STN_BASE     = 7,
  parameter logic [47:0] STATION_ADDR = 48'h5254_0012_3456
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int STN_WORDS = 3;

  function automatic logic [DATA_W-1:0] init_word(input int idx);
    logic [DATA_W-1:0] w;
    w = '0;
    if (idx == 0) w = DATA_W'(ID_WORD0);
    if (idx == 1) w = DATA_W'(ID_WORD1);
    if (idx == 2) w = DATA_W'(ID_WORD2);
    for (int j = 0; j < STN_WORDS; j++) begin
      if (idx == STN_BASE + j) begin
        w = DATA_W'({STATION_ADDR[39-16*j -: 8], STATION_ADDR[47-16*j -: 8]});
      end
    end
    return w;
  endfunction

  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= init_word(w);
      else        word_q <= word_q;
    end
    assign words[w] = word_q;
  end

  assign rd_word = words[rd_addr];

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output mw_state_t         state,
  output logic [CNT_W-1:0]  cnt
);

  mw_state_t         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [OPC_W-1:0]  opc_q, opc_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic              dout_q, dout_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    opc_n   = opc_q;
    addr_n  = addr_q;
    shreg_n = shreg_q;
    dout_n  = dout_q;
    if (!sel_s) begin
      state_n = ST_WAIT;
      cnt_n   = '0;
      opc_n   = '0;
      shreg_n = '0;
      dout_n  = 1'b1;
    end else if (sclk_rise) begin
      unique case (state_q)
        ST_WAIT: begin
          if (sdi_s) begin
            state_n = ST_OPC;
            cnt_n   = '0;
          end
        end
        ST_OPC: begin
          opc_n = {opc_q[OPC_W-2:0], sdi_s};
          if (cnt_q == CNT_W'(OPC_W - 1)) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_n = {addr_q[ADDR_W-2:0], sdi_s};
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_n = '0;
            if (opc_q == OPC_READ) begin
              state_n = ST_DUMMY;
              dout_n  = 1'b0;
            end else begin
              state_n = ST_WAIT;
              dout_n  = 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          shreg_n = rd_word;
          dout_n  = rd_word[DATA_W-1];
          cnt_n   = '0;
          state_n = ST_READ;
        end
        ST_READ: begin
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            state_n = ST_WAIT;
            cnt_n   = '0;
            opc_n   = '0;
            shreg_n = '0;
            dout_n  = 1'b1;
          end else begin
            shreg_n = {shreg_q[DATA_W-2:0], 1'b0};
            dout_n  = shreg_q[DATA_W-2];
            cnt_n   = cnt_q + 1'b1;
          end
        end
        default: begin
          state_n = ST_WAIT;
          dout_n  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      shreg_q <= '0;
      dout_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      opc_q   <= opc_n;
      addr_q  <= addr_n;
      shreg_q <= shreg_n;
      dout_q  <= dout_n;
    end
  end

  assign rd_addr = addr_q;
  assign dout    = dout_q;
  assign state   = state_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/mw_eeprom_responder.sv
module mw_eeprom_responder
  import mw_eeprom_pkg::*;
#(
  parameter int          ADDR_W       = 6,
  parameter int          DATA_W       = 16,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [15:0] ID_WORD0     = 16'h8129,
  parameter logic [15:0] ID_WORD1     = 16'h10EC,
  parameter logic [15:0] ID_WORD2     = 16'h8139,
  parameter int          STN_BASE     = 7,
  parameter logic [47:0] STATION_ADDR = 48'h5254_0012_3456
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);

  localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic              rst_n_s;
  logic              sel_s;
  logic              sdi_s;
  logic              sclk_rise;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;
  logic              dout;
  mw_state_t         state_w;
  logic [CNT_W-1:0]  cnt_w;

  mw_line_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .RST_STAGES  (2)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .rst_n_s   (rst_n_s),
    .sel_s     (sel_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise)
  );

  mw_word_store #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ID_WORD0     (ID_WORD0),
    .ID_WORD1     (ID_WORD1),
    .ID_WORD2     (ID_WORD2),
    .STN_BASE     (STN_BASE),
    .STATION_ADDR (STATION_ADDR)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  mw_cmd_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sel_s     (sel_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .dout      (dout),
    .state     (state_w),
    .cnt       (cnt_w)
  );

  assign sdo_o = sel_s & dout;

endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_s,
  input logic             sdi_s,
  input logic             sclk_rise,
  input logic             sdo_o,
  input mw_state_t        state_w,
  input logic [CNT_W-1:0] cnt_w
);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && (state_w == ST_WAIT || state_w == ST_OPC || state_w == ST_ADDR)) |-> sdo_o); // R2

  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && state_w == ST_WAIT && sclk_rise && !sdi_s) |=> state_w == ST_WAIT); // R3

  AST_ADDR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_ADDR) |-> (int'(cnt_w) < ADDR_W)); // R4

  AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && state_w == ST_DUMMY) |-> !sdo_o); // R5

  AST_READ_AFTER_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_READ && $past(state_w) != ST_READ) |-> $past(state_w) == ST_DUMMY); // R6

  AST_END_OF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && state_w == ST_READ && sclk_rise && int'(cnt_w) == DATA_W - 1) |=> state_w == ST_WAIT); // R7

  AST_DESELECT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> state_w == ST_WAIT); // R8

endmodule

bind mw_eeprom_responder mw_eeprom_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_s     (sel_s),
  .sdi_s     (sdi_s),
  .sclk_rise (sclk_rise),
  .sdo_o     (sdo_o),
  .state_w   (state_w),
  .cnt_w     (cnt_w)
);

// File: tb/mw_eeprom_responder_tb_top.sv
module mw_eeprom_responder_tb_top;

  localparam int PH = 8;

  logic clk;
  logic rst_n;
  logic sel;
  logic sclk;
  logic sdi;
  logic sdo;

  int checks;
  int errors;

  mw_eeprom_responder dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel),
    .sclk_i (sclk),
    .sdi_i  (sdi),
    .sdo_o  (sdo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected contents, from R1 and the default 48'h5254_0012_3456
  function automatic logic [15:0] exp_word(input int a);
    case (a)
      0: return 16'h8129;
      1: return 16'h10EC;
      2: return 16'h8139;
      7: return 16'h5452;
      8: return 16'h1200;
      9: return 16'h5634;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  // one serial clock period, ends just after the rising edge has settled
  task automatic sk_cycle(input logic b);
    sdi  = b;
    sclk = 1'b0;
    tick(PH);
    sclk = 1'b1;
    tick(PH);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a);
    sk_cycle(1'b1);
    sk_cycle(op[1]);
    sk_cycle(op[0]);
    for (int i = 5; i >= 0; i--) sk_cycle(a[i]);
  endtask

  task automatic do_read(input int a, input logic term_di);
    logic [15:0] w;
    logic [15:0] got;
    w = exp_word(a);
    send_cmd(2'b10, 6'(a));
    chk(sdo == 1'b0, "R5 dummy bit", 32'(sdo), 32'h0);
    got = '0;
    for (int i = 15; i >= 0; i--) begin
      sk_cycle(1'b0);
      got[i] = sdo;
    end
    chk(got == w, "R1/R4/R6 read word", 32'(got), 32'(w));
    sk_cycle(term_di);
    chk(sdo == 1'b1, "R7 back to wait", 32'(sdo), 32'h1);
  endtask

  task automatic deselect_cycle();
    sclk = 1'b0;
    sel  = 1'b0;
    tick(PH);
    @(negedge clk);
    chk(sdo == 1'b0, "R2/R8 select low", 32'(sdo), 32'h0);
    sel = 1'b1;
    tick(PH);
    @(negedge clk);
    chk(sdo == 1'b1, "R8 ready after reselect", 32'(sdo), 32'h1);
  endtask

  initial begin
    int n;
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    sel    = 1'b0;
    sclk   = 1'b0;
    sdi    = 1'b0;
    void'($urandom(32'd20240611));
    tick(5);
    @(negedge clk);
    chk(sdo == 1'b0, "R2 reset output", 32'(sdo), 32'h0);
    rst_n = 1'b1;
    tick(6);
    sel = 1'b1;
    tick(PH);
    @(negedge clk);
    chk(sdo == 1'b1, "R2 idle ready", 32'(sdo), 32'h1);

    // R3: idle zeros ignored
    for (int i = 0; i < 4; i++) sk_cycle(1'b0);
    chk(sdo == 1'b1, "R3 zeros ignored", 32'(sdo), 32'h1);

    // R1: identity and station words, plus blank words
    do_read(0, 1'b0);
    do_read(1, 1'b0);
    do_read(2, 1'b0);
    do_read(7, 1'b0);
    do_read(8, 1'b0);
    do_read(9, 1'b0);
    do_read(5, 1'b0);
    do_read(63, 1'b0);

    // R7: high data-in on the closing edge is ignored, no auto increment
    do_read(0, 1'b1);
    do_read(1, 1'b1);
    do_read(1, 1'b0);

    // R8: abort during the address and during the data
    sk_cycle(1'b1);
    sk_cycle(1'b1);
    sk_cycle(1'b0);
    sk_cycle(1'b1);
    deselect_cycle();
    do_read(2, 1'b0);
    send_cmd(2'b10, 6'd7);
    for (int i = 0; i < 5; i++) sk_cycle(1'b0);
    deselect_cycle();
    do_read(8, 1'b0);

    // R9: other operation codes
    send_cmd(2'b11, 6'd0);
    chk(sdo == 1'b1, "R9 op 11 accepted", 32'(sdo), 32'h1);
    do_read(0, 1'b0);
    send_cmd(2'b01, 6'd1);
    chk(sdo == 1'b1, "R9 op 01 accepted", 32'(sdo), 32'h1);
    do_read(1, 1'b0);
    send_cmd(2'b00, 6'd9);
    chk(sdo == 1'b1, "R9 op 00 accepted", 32'(sdo), 32'h1);
    do_read(9, 1'b0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind;
      int a;
      n = $urandom_range(0, 3);
      for (int z = 0; z < n; z++) sk_cycle(1'b0);
      kind = $urandom_range(0, 9);
      a    = (kind < 6) ? $urandom_range(0, 12) : $urandom_range(0, 63);
      if (kind == 0) begin
        n = $urandom_range(1, 20);
        send_cmd(2'b10, 6'(a));
        for (int z = 0; z < n; z++) sk_cycle(1'($urandom_range(0, 1)));
        deselect_cycle();
      end else if (kind == 1) begin
        send_cmd(2'($urandom_range(0, 1)), 6'(a));
        chk(sdo == 1'b1, "R9 random non-read", 32'(sdo), 32'h1);
      end else begin
        do_read(a, 1'($urandom_range(0, 1)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule